// File: doc/BRIEF.md
# Floppy Drive Select and Motor Decoder

This block drives the control lines that run from a floppy disk controller to its drives. It holds a copy of the digital output register (drive number, a run/reset bit and one motor bit per drive) and of the data-rate register. From these it makes one motor enable and one drive select per drive, and a density-select line that tracks the programmed rate. It also passes the head-side, step-direction, step and write-gate requests from the controller core to the drive cable. A drive select can only go active while that drive's motor is on. While the run bit is clear, the motors, selects, step and write gate are all held off.

Two board straps set the electrical levels. The polarity strap makes every cable output active low, which suits the on-chip buffers, or active high, which suits external inverting drivers. The identity input sets which level of density select marks a high data rate. Every output comes straight from a flip-flop, so a change of drive number cannot glitch a select line on the cable.

This block has no streaming data path. All of its pins are plain control and status levels with no valid/ready handshake.

Top module: `fdc_drive_ctl`

## Requirements
- R1: With run bit 2 of the output register set, motor enable i is active exactly when register bit 4+i is 1.
- R2: Drive select i is active only when register bits 1:0 equal i and motor enable i is active, so at most one select is active at a time.
- R3: With the polarity strap at 0, an active output is driven low. With the strap at 1, an active output is driven high. This applies to motors, selects, head, direction, step and write gate.
- R4: Rate codes 00 (500 kbps) and 11 (1 Mbps) count as high rates, and 01 (300 kbps) and 10 (250 kbps) as low rates. With the identity input at 1, density select is high for a high rate. With it at 0, density select is low for a high rate. The polarity strap does not affect density select.
- R5: Head select is active when the core requests side 1.
- R6: Direction is active when the core requests a step toward the disk centre.
- R7: While run bit 2 is 0, motors, selects, step and write gate are inactive whatever is requested. Head, direction and density keep following their inputs.
- R8: Hardware reset clears the output register to 00h and sets the rate to 10 (250 kbps). During reset every gated output sits at its inactive level for the current polarity strap.
- R9: A register write, or any change on a request input, reaches the pins at the clock edge that samples it. When its write enable is low, a register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous hardware reset, active low |
| strap_invert | input | 1 | Polarity strap: 0 = active-low outputs, 1 = active-high outputs |
| ident_i | input | 1 | Identity input; selects the density-select polarity |
| dor_wr_en | input | 1 | Write strobe for the output register |
| dor_wdata | input | 8 | Output register data: [1:0] drive, [2] run, [7:4] motors |
| rate_wr_en | input | 1 | Write strobe for the data-rate register |
| rate_wdata | input | 2 | Data-rate code |
| head_side_i | input | 1 | Core request for side 1 |
| dir_inward_i | input | 1 | Core request for stepping toward the centre |
| step_req_i | input | 1 | Core step pulse request |
| wgate_req_i | input | 1 | Core write gate request |
| motor_o | output | 4 | Motor enables, one per drive |
| drvsel_o | output | 4 | Drive selects, one per drive |
| dens_o | output | 1 | Density select |
| head_o | output | 1 | Head select |
| dir_o | output | 1 | Step direction |
| step_o | output | 1 | Step |
| wgate_o | output | 1 | Write enable |

## Verification
Two events can fall on the same clock edge: an output-register write that clears the run bit, and a step or write-gate request from the core. The bench raises the step and write-gate requests one cycle before that write and keeps them raised through the write edge. It then expects step, write gate, motors and selects to go inactive at that edge, while head select still follows its request. A second pairing writes a new drive number and a new rate in one cycle. Select and density must change at the same edge.

// File: rtl/fdc_drv_pkg.sv
package fdc_drv_pkg;

  typedef enum logic [1:0] {
    RATE_500K = 2'b00,
    RATE_300K = 2'b01,
    RATE_250K = 2'b10,
    RATE_1M   = 2'b11
  } rate_e;

  localparam int unsigned RUN_BIT   = 2;
  localparam int unsigned MOTOR_LSB = 4;
  localparam int unsigned SEL_LSB   = 0;

  typedef struct packed {
    logic wgate;
    logic step;
    logic dir;
    logic head;
  } aux_t;

  function automatic logic rate_is_high(rate_e r);
    return (r == RATE_500K) || (r == RATE_1M);
  endfunction

  // active request -> cable level for the given polarity strap
  function automatic logic to_pin(logic act, logic strap);
    return ~(act ^ strap);
  endfunction

  function automatic logic dens_level(rate_e r, logic ident);
    return ident ? rate_is_high(r) : ~rate_is_high(r);
  endfunction

endpackage

// File: rtl/fdc_ctl_regs.sv
module fdc_ctl_regs
  import fdc_drv_pkg::*;
#(
  parameter int unsigned DOR_W    = 8,
  parameter rate_e       RATE_RST = RATE_250K
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dor_wr_en,
  input  logic [DOR_W-1:0] dor_wdata,
  input  logic             rate_wr_en,
  input  logic [1:0]       rate_wdata,
  output logic [DOR_W-1:0] dor_nxt,
  output rate_e            rate_nxt
);

  logic [DOR_W-1:0] dor_q;
  rate_e            rate_q;

  // next-state view: a write is visible to the output stage at its own edge
  always_comb begin
    dor_nxt  = dor_wr_en  ? dor_wdata          : dor_q;
    rate_nxt = rate_wr_en ? rate_e'(rate_wdata) : rate_q;
    if (!rst_n) begin
      dor_nxt  = '0;
      rate_nxt = RATE_RST;
    end
  end

  always_ff @(posedge clk) begin
    dor_q  <= dor_nxt;
    rate_q <= rate_nxt;
  end

endmodule

// File: rtl/fdc_sel_decode.sv
module fdc_sel_decode
  import fdc_drv_pkg::*;
#(
  parameter int unsigned NUM_DRIVES = 4,
  localparam int unsigned SEL_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic [SEL_W-1:0]      drive_num,
  input  logic                  run,
  input  logic [NUM_DRIVES-1:0] motor_bits,
  output logic [NUM_DRIVES-1:0] mot_act,
  output logic [NUM_DRIVES-1:0] sel_act
);

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
    logic hit;
    assign hit        = (drive_num == SEL_W'(d));
    assign mot_act[d] = run & motor_bits[d];
    assign sel_act[d] = hit & mot_act[d];
  end

endmodule

// File: rtl/fdc_pin_stage.sv
module fdc_pin_stage
  import fdc_drv_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strap,
  input  logic [W-1:0] act,
  output logic [W-1:0] pins
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) pins[b] <= to_pin(1'b0, strap);
      else        pins[b] <= to_pin(act[b], strap);
    end
  end

endmodule

// File: rtl/fdc_drive_ctl.sv
module fdc_drive_ctl
  import fdc_drv_pkg::*;
#(
  parameter int unsigned NUM_DRIVES = 4,
  parameter int unsigned DOR_W      = 8,
  localparam int unsigned SEL_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1,
  localparam int unsigned PIN_W     = 2 * NUM_DRIVES + $bits(aux_t)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  strap_invert,
  input  logic                  ident_i,
  input  logic                  dor_wr_en,
  input  logic [DOR_W-1:0]      dor_wdata,
  input  logic                  rate_wr_en,
  input  logic [1:0]            rate_wdata,
  input  logic                  head_side_i,
  input  logic                  dir_inward_i,
  input  logic                  step_req_i,
  input  logic                  wgate_req_i,
  output logic [NUM_DRIVES-1:0] motor_o,
  output logic [NUM_DRIVES-1:0] drvsel_o,
  output logic                  dens_o,
  output logic                  head_o,
  output logic                  dir_o,
  output logic                  step_o,
  output logic                  wgate_o
);

  localparam rate_e RATE_RST = RATE_250K;

  logic [DOR_W-1:0]      dor_nxt;
  rate_e                 rate_nxt;
  logic                  run;
  logic [NUM_DRIVES-1:0] mot_act, sel_act;
  aux_t                  aux_act;
  logic [PIN_W-1:0]      act_vec, pin_vec;
  logic                  dor_spare_unused;

  fdc_ctl_regs #(.DOR_W(DOR_W), .RATE_RST(RATE_RST)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .dor_wr_en  (dor_wr_en),
    .dor_wdata  (dor_wdata),
    .rate_wr_en (rate_wr_en),
    .rate_wdata (rate_wdata),
    .dor_nxt    (dor_nxt),
    .rate_nxt   (rate_nxt)
  );

  assign run              = dor_nxt[RUN_BIT];
  assign dor_spare_unused = ^{dor_nxt[DOR_W-1:MOTOR_LSB+NUM_DRIVES-1], dor_nxt[MOTOR_LSB-1:RUN_BIT]};

  fdc_sel_decode #(.NUM_DRIVES(NUM_DRIVES)) u_dec (
    .drive_num  (dor_nxt[SEL_LSB +: SEL_W]),
    .run        (run),
    .motor_bits (dor_nxt[MOTOR_LSB +: NUM_DRIVES]),
    .mot_act    (mot_act),
    .sel_act    (sel_act)
  );

  always_comb begin
    aux_act.head  = head_side_i;
    aux_act.dir   = dir_inward_i;
    aux_act.step  = step_req_i & run;
    aux_act.wgate = wgate_req_i & run;
  end

  assign act_vec = {aux_act, sel_act, mot_act};

  fdc_pin_stage #(.W(PIN_W)) u_pins (
    .clk   (clk),
    .rst_n (rst_n),
    .strap (strap_invert),
    .act   (act_vec),
    .pins  (pin_vec)
  );

  always_ff @(posedge clk) begin
    dens_o <= dens_level(rate_nxt, ident_i);
  end

  assign motor_o  = pin_vec[0 +: NUM_DRIVES];
  assign drvsel_o = pin_vec[NUM_DRIVES +: NUM_DRIVES];
  assign head_o   = pin_vec[2*NUM_DRIVES + 0];
  assign dir_o    = pin_vec[2*NUM_DRIVES + 1];
  assign step_o   = pin_vec[2*NUM_DRIVES + 2];
  assign wgate_o  = pin_vec[2*NUM_DRIVES + 3];

endmodule

// File: rtl/fdc_drive_ctl_chk.sv
module fdc_drive_ctl_chk #(
  parameter int unsigned NUM_DRIVES = 4,
  parameter int unsigned DOR_W      = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  strap_invert,
  input logic                  ident_i,
  input logic                  dor_wr_en,
  input logic [DOR_W-1:0]      dor_wdata,
  input logic                  rate_wr_en,
  input logic [1:0]            rate_wdata,
  input logic                  head_side_i,
  input logic                  dir_inward_i,
  input logic [NUM_DRIVES-1:0] motor_o,
  input logic [NUM_DRIVES-1:0] drvsel_o,
  input logic                  dens_o,
  input logic                  head_o,
  input logic                  dir_o,
  input logic                  step_o,
  input logic                  wgate_o
);

  logic                  inv_q;
  logic [NUM_DRIVES-1:0] mot_a, sel_a;
  logic                  head_a, dir_a, step_a, wg_a;

  always_ff @(posedge clk) inv_q <= strap_invert;

  always_comb begin
    mot_a  = inv_q ? motor_o  : ~motor_o;
    sel_a  = inv_q ? drvsel_o : ~drvsel_o;
    head_a = inv_q ? head_o   : ~head_o;
    dir_a  = inv_q ? dir_o    : ~dir_o;
    step_a = inv_q ? step_o   : ~step_o;
    wg_a   = inv_q ? wgate_o  : ~wgate_o;
  end

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_a));

  // R2
  sel_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a & ~mot_a) == '0);

  // R1
  motor_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dor_wr_en && dor_wdata[2]) |=> (mot_a == $past(dor_wdata[4 +: NUM_DRIVES])));

  // R7
  run_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dor_wr_en && !dor_wdata[2]) |=> (mot_a == '0 && sel_a == '0 && !step_a && !wg_a));

  // R4
  dens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_wr_en |=> (dens_o == ($past(ident_i) ==
      ($past(rate_wdata) == 2'b00 || $past(rate_wdata) == 2'b11))));

  // R5
  head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (head_a == $past(head_side_i)));

  // R6
  dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dir_a == $past(dir_inward_i)));

endmodule

bind fdc_drive_ctl fdc_drive_ctl_chk #(.NUM_DRIVES(NUM_DRIVES), .DOR_W(DOR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .strap_invert (strap_invert),
  .ident_i      (ident_i),
  .dor_wr_en    (dor_wr_en),
  .dor_wdata    (dor_wdata),
  .rate_wr_en   (rate_wr_en),
  .rate_wdata   (rate_wdata),
  .head_side_i  (head_side_i),
  .dir_inward_i (dir_inward_i),
  .motor_o      (motor_o),
  .drvsel_o     (drvsel_o),
  .dens_o       (dens_o),
  .head_o       (head_o),
  .dir_o        (dir_o),
  .step_o       (step_o),
  .wgate_o      (wgate_o)
);

// File: tb/sim_fdc_drive_ctl.sv
module sim_fdc_drive_ctl;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       strap_invert, ident_i;
  logic       dor_wr_en, rate_wr_en;
  logic [7:0] dor_wdata;
  logic [1:0] rate_wdata;
  logic       head_side_i, dir_inward_i, step_req_i, wgate_req_i;
  logic [3:0] motor_o, drvsel_o;
  logic       dens_o, head_o, dir_o, step_o, wgate_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  fdc_drive_ctl u0 (
    .clk(clk), .rst_n(rst_n), .strap_invert(strap_invert), .ident_i(ident_i),
    .dor_wr_en(dor_wr_en), .dor_wdata(dor_wdata),
    .rate_wr_en(rate_wr_en), .rate_wdata(rate_wdata),
    .head_side_i(head_side_i), .dir_inward_i(dir_inward_i),
    .step_req_i(step_req_i), .wgate_req_i(wgate_req_i),
    .motor_o(motor_o), .drvsel_o(drvsel_o), .dens_o(dens_o),
    .head_o(head_o), .dir_o(dir_o), .step_o(step_o), .wgate_o(wgate_o)
  );

  // {strap, ident, dor, rate, head, dir, step, wgate, exp motor, exp sel, exp dens/head/dir/step/wgate}
  localparam logic [28:0] VEC [8] = '{
    {1'b1, 1'b1, 8'h14, 2'b00, 4'b1010, 4'b0001, 4'b0001, 5'b11010},
    {1'b1, 1'b1, 8'h25, 2'b10, 4'b0101, 4'b0010, 4'b0010, 5'b00101},
    {1'b1, 1'b0, 8'h26, 2'b11, 4'b1111, 4'b0010, 4'b0000, 5'b01111},
    {1'b0, 1'b0, 8'hF7, 2'b01, 4'b0000, 4'b0000, 4'b0111, 5'b11111},
    {1'b0, 1'b1, 8'hF3, 2'b00, 4'b1111, 4'b1111, 4'b1111, 5'b10011},
    {1'b1, 1'b0, 8'h84, 2'b01, 4'b0000, 4'b1000, 4'b0000, 5'b10000},
    {1'b0, 1'b1, 8'h4E, 2'b10, 4'b1001, 4'b1011, 4'b1011, 5'b00110},
    {1'b1, 1'b1, 8'h00, 2'b11, 4'b0111, 4'b0000, 4'b0000, 5'b10100}
  };

  function automatic logic [12:0] pins();
    return {motor_o, drvsel_o, dens_o, head_o, dir_o, step_o, wgate_o};
  endfunction

  task automatic check(input string tag, input logic [12:0] exp);
    checks++;
    if (pins() !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, pins(), exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic set_req(input logic [3:0] r);
    {head_side_i, dir_inward_i, step_req_i, wgate_req_i} = r;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; strap_invert = 1'b0; ident_i = 1'b1;
    dor_wr_en = 1'b0; rate_wr_en = 1'b0; dor_wdata = '0; rate_wdata = '0;
    set_req(4'b0000);
    repeat (3) tick();
    // R8 R3: reset, active-low strap, low rate with ident 1
    check("R8 reset strap0", {4'hF, 4'hF, 5'b01111});
    strap_invert = 1'b1; ident_i = 1'b0;
    tick();
    // R8 R4: reset, active-high strap, ident 0 gives high level for low rate
    check("R8 reset strap1", {4'h0, 4'h0, 5'b10000});
    rst_n = 1'b1;

    // table: R1 R2 R3 R4 R5 R6 R7 combined vectors
    for (int i = 0; i < 8; i++) begin
      strap_invert = VEC[i][28];
      ident_i      = VEC[i][27];
      dor_wdata    = VEC[i][26:19];
      rate_wdata   = VEC[i][18:17];
      set_req(VEC[i][16:13]);
      dor_wr_en = 1'b1; rate_wr_en = 1'b1;
      tick();
      check($sformatf("R1 R2 R3 R4 R5 R6 R7 vector %0d", i), VEC[i][12:0]);
      dor_wr_en = 1'b0; rate_wr_en = 1'b0;
    end

    // R9: output register write alone, rate kept at 1 Mbps
    set_req(4'b0000);
    dor_wdata = 8'h15; dor_wr_en = 1'b1;
    tick();
    check("R9 dor write only", {4'b0001, 4'b0000, 5'b10000});
    dor_wr_en = 1'b0; dor_wdata = 8'hF7;
    tick();
    check("R9 data without strobe ignored", {4'b0001, 4'b0000, 5'b10000});

    // R4: rate write alone to 250 kbps
    rate_wdata = 2'b10; rate_wr_en = 1'b1;
    tick();
    rate_wr_en = 1'b0;
    check("R4 rate write only", {4'b0001, 4'b0000, 5'b00000});

    // R7 collision: run bit cleared in the same cycle as step/write gate
    dor_wdata = 8'hF4; dor_wr_en = 1'b1; set_req(4'b0011);
    tick();
    check("R7 running step and gate", {4'b1111, 4'b0001, 5'b00011});
    dor_wdata = 8'hF0; set_req(4'b1011);
    tick();
    check("R7 run cleared same cycle", {4'b0000, 4'b0000, 5'b01000});
    dor_wr_en = 1'b0; set_req(4'b0000);

    // R2 select moves in one edge, rate change lands on the same edge
    dor_wdata = 8'h34; dor_wr_en = 1'b1;
    tick();
    check("R2 select drive 0", {4'b0011, 4'b0001, 5'b00000});
    dor_wdata = 8'h35; rate_wdata = 2'b00; rate_wr_en = 1'b1;
    tick();
    check("R2 R4 select drive 1 with rate", {4'b0011, 4'b0010, 5'b10000});
    dor_wr_en = 1'b0; rate_wr_en = 1'b0;

    // R8 hardware reset mid-run, then registers cleared
    rst_n = 1'b0;
    tick();
    check("R8 reset mid-run", {4'b0000, 4'b0000, 5'b00000});
    rst_n = 1'b1; ident_i = 1'b0;
    tick();
    check("R8 cleared after reset", {4'b0000, 4'b0000, 5'b10000});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule